// File: doc/BRIEF.md
# TMDS symbol decoder

This block turns the 10-bit transition-minimised symbols arriving on one video link channel back into the signals that produced them. Each cycle it may accept one symbol, already framed on the correct word boundary, together with a valid strobe. One clock later it presents a data-enable flag, the horizontal and vertical sync bits, an 8-bit pixel value and an output valid.

A symbol is treated as a control symbol only when it exactly equals one of four fixed control codes. The position of that code in the table gives the two sync bits. Every other symbol is treated as pixel data. The byte is recovered with one XOR expression per bit. That expression folds in both the optional inversion flagged by symbol bit 9 and the XOR/XNOR choice flagged by symbol bit 8. The block does not check disparity or errors, and it does no alignment. It is meant to sit behind a deserialiser and word aligner, with one instance per colour channel.

Top module: `tmds_symbol_decoder`

## Requirements
- R1: `out_valid` equals `sym_valid` delayed by exactly one clock, and a decoded result appears on the outputs on the clock edge after its symbol is accepted.
- R2: The control codes are index 0 = 10'b1101010100, 1 = 10'b0010101011, 2 = 10'b0101010100 and 3 = 10'b1010101011. When a valid symbol equals one of them, `de` goes low, `hsync` takes index bit 0 and `vsync` takes index bit 1.
- R3: When a valid symbol matches no control code, `de` goes high and `hsync` and `vsync` are 0.
- R4: For a data symbol, `pix[0]` equals `sym_in[0]` XOR `sym_in[9]`.
- R5: For a data symbol and for i from 1 to 7, `pix[i]` equals `sym_in[i]` XOR `sym_in[i-1]` XOR NOT `sym_in[8]`. Every byte encoded by a DC-balancing transmitter therefore comes back unchanged.
- R6: `pix` is 0 whenever `de` is low.
- R7: While the synchronous active-high `rst` is high on a clock edge, `de`, `hsync`, `vsync`, `pix` and `out_valid` are cleared to 0.
- R8: A cycle with `sym_valid` low leaves `de`, `hsync`, `vsync` and `pix` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol strobe |
| sym_in | input | 10 | Word-aligned received symbol |
| out_valid | output | 1 | Decoded result strobe |
| de | output | 1 | High for a pixel-data symbol |
| hsync | output | 1 | Horizontal sync from the control index |
| vsync | output | 1 | Vertical sync from the control index |
| pix | output | 8 | Recovered pixel byte |

## Verification
The only state is the single output register. A wrong state or a wrong decode therefore shows at the ports on the very next edge after the symbol. It appears as a flipped sync bit, a data byte on a control symbol, a byte off by a chained XOR, or a missing or extra valid pulse. The bench sweeps all 1024 symbol values against expectations computed from the bit formulas. It then round-trips every byte and 500 pseudo-random bytes through a reference encoder in the bench, so the first wrong symbol is reported in the cycle it decodes.

// File: rtl/tmds_dec_pkg.sv
package tmds_dec_pkg;

    localparam int DATA_W     = 8;
    localparam int SYM_W      = DATA_W + 2;
    localparam int NUM_CTRL   = 4;
    localparam int CTRL_IDX_W = $clog2(NUM_CTRL);
    localparam int INV_BIT    = SYM_W - 1;   // set when the data bits were inverted
    localparam int MODE_BIT   = SYM_W - 2;   // set when the XOR chain was used

    typedef logic [SYM_W-1:0]      sym_t;
    typedef logic [DATA_W-1:0]     byte_t;
    typedef logic [CTRL_IDX_W-1:0] ctl_idx_t;

    typedef struct packed {
        logic     de;
        ctl_idx_t ctl;    // bit 1 = vsync, bit 0 = hsync
        byte_t    data;
    } dec_word_t;

    // Control code table, indexed by the sync pair it carries
    function automatic sym_t ctrl_code(input int idx);
        case (idx)
            0:       return 10'b1101010100;
            1:       return 10'b0010101011;
            2:       return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

endpackage

// File: rtl/tmds_ctrl_match.sv
module tmds_ctrl_match
    import tmds_dec_pkg::*;
(
    input  sym_t     sym,
    output logic     is_ctrl,
    output ctl_idx_t idx
);
    logic [NUM_CTRL-1:0] hit;

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_cmp
        assign hit[k] = (sym == ctrl_code(k));
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < NUM_CTRL; k++) begin
            if (hit[k]) idx = idx | ctl_idx_t'(k);
        end
    end

    assign is_ctrl = |hit;
endmodule

// File: rtl/tmds_data_unxor.sv
module tmds_data_unxor
    import tmds_dec_pkg::*;
(
    input  sym_t  sym,
    output byte_t data
);
    // Inversion cancels in each adjacent pair; only bit 0 needs the flag.
    assign data[0] = sym[0] ^ sym[INV_BIT];

    for (genvar i = 1; i < DATA_W; i++) begin : g_bit
        assign data[i] = sym[i] ^ sym[i-1] ^ ~sym[MODE_BIT];
    end
endmodule

// File: rtl/tmds_dec_outreg.sv
module tmds_dec_outreg
    import tmds_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  dec_word_t in_word,
    output logic      out_valid,
    output dec_word_t out_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_word <= in_word;
        end
    end
endmodule

// File: rtl/tmds_symbol_decoder.sv
module tmds_symbol_decoder
    import tmds_dec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sym_valid,
    input  logic [9:0]  sym_in,
    output logic        out_valid,
    output logic        de,
    output logic        hsync,
    output logic        vsync,
    output logic [7:0]  pix
);
    logic      is_ctrl;
    ctl_idx_t  ctl_idx;
    byte_t     raw_data;
    dec_word_t nxt_word;
    dec_word_t cur_word;

    tmds_ctrl_match u_match (
        .sym     (sym_in),
        .is_ctrl (is_ctrl),
        .idx     (ctl_idx)
    );

    tmds_data_unxor u_unxor (
        .sym  (sym_in),
        .data (raw_data)
    );

    always_comb begin
        nxt_word.de   = ~is_ctrl;
        nxt_word.ctl  = is_ctrl ? ctl_idx : '0;
        nxt_word.data = is_ctrl ? '0 : raw_data;
    end

    tmds_dec_outreg u_reg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sym_valid),
        .in_word   (nxt_word),
        .out_valid (out_valid),
        .out_word  (cur_word)
    );

    assign de    = cur_word.de;
    assign hsync = cur_word.ctl[0];
    assign vsync = cur_word.ctl[1];
    assign pix   = cur_word.data;
endmodule

// File: rtl/tmds_symbol_decoder_chk.sv
module tmds_symbol_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       sym_valid,
    input logic [9:0] sym_in,
    input logic       out_valid,
    input logic       de,
    input logic       hsync,
    input logic       vsync,
    input logic [7:0] pix
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) sym_valid |=> out_valid); // R1
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst) !sym_valid |=> !out_valid); // R1
    AST_CODE0_SYNC: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_in == 10'b1101010100) |=> (!de && !hsync && !vsync)); // R2
    AST_CODE3_SYNC: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_in == 10'b1010101011) |=> (!de && hsync && vsync)); // R2
    AST_DATA_NO_SYNC: assert property (@(posedge clk) disable iff (rst) de |-> (!hsync && !vsync)); // R3
    AST_BIT0_FOLD: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> (!de || pix[0] == ($past(sym_in[0]) ^ $past(sym_in[9])))); // R4
    AST_BIT1_CHAIN: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> (!de || pix[1] == ($past(sym_in[1]) ^ $past(sym_in[0]) ^ ~$past(sym_in[8])))); // R5
    AST_CTRL_ZERO_PIX: assert property (@(posedge clk) disable iff (rst) !de |-> (pix == 8'h00)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> ($stable(de) && $stable(hsync) && $stable(vsync) && $stable(pix))); // R8
endmodule

bind tmds_symbol_decoder tmds_symbol_decoder_chk chk_i (.*);

// File: tb/tmds_symbol_decoder_tb.sv
module tmds_symbol_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [9:0] sym_in = '0;
    logic       out_valid, de, hsync, vsync;
    logic [7:0] pix;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    int disp = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic       last_de = 1'b0, last_hs = 1'b0, last_vs = 1'b0;
    logic [7:0] last_pix = '0;

    always #10 clk = ~clk;

    tmds_symbol_decoder dut_i (.*);

    function automatic logic [9:0] code_of(input int k);
        case (k)
            0: return 10'b1101010100;
            1: return 10'b0010101011;
            2: return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    // Reference DC-balancing transmitter; updates the running disparity
    function automatic logic [9:0] encode(input logic [7:0] d);
        logic [8:0] qm;
        logic       use_xnor;
        int         n1, n0;
        logic [9:0] s;
        use_xnor = ($countones(d) > 4) || ($countones(d) == 4 && !d[0]);
        qm[0] = d[0];
        for (int i = 1; i < 8; i++) qm[i] = use_xnor ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
        qm[8] = !use_xnor;
        n1 = $countones(qm[7:0]);
        n0 = 8 - n1;
        if (disp == 0 || n1 == n0) begin
            s = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
            disp += qm[8] ? (n1 - n0) : (n0 - n1);
        end else if ((disp > 0 && n1 > n0) || (disp < 0 && n0 > n1)) begin
            s = {1'b1, qm[8], ~qm[7:0]};
            disp += (qm[8] ? 2 : 0) + n0 - n1;
        end else begin
            s = {1'b0, qm[8], qm[7:0]};
            disp += n1 - n0 - (qm[8] ? 0 : 2);
        end
        return s;
    endfunction

    task automatic check(input string tag, input logic ev, input logic ed, input logic eh,
                         input logic evs, input logic [7:0] ep);
        n_run++;
        if (out_valid !== ev || de !== ed || hsync !== eh || vsync !== evs || pix !== ep) begin
            n_fail++;
            $display("FAIL %s: got v=%b de=%b hs=%b vs=%b pix=%h, expected v=%b de=%b hs=%b vs=%b pix=%h",
                     tag, out_valid, de, hsync, vsync, pix, ev, ed, eh, evs, ep);
        end
    endtask

    // Drive at a falling edge; the result is visible at the next falling edge
    task automatic step(input string tag, input logic v, input logic [9:0] s,
                        input logic ed, input logic eh, input logic evs, input logic [7:0] ep);
        @(negedge clk);
        sym_valid = v;
        sym_in    = s;
        @(negedge clk);
        if (v) begin
            check(tag, 1'b1, ed, eh, evs, ep);
            last_de = ed; last_hs = eh; last_vs = evs; last_pix = ep;
        end else begin
            check(tag, 1'b0, last_de, last_hs, last_vs, last_pix);
        end
    endtask

    task automatic send_byte(input string tag, input logic [7:0] b);
        step(tag, 1'b1, encode(b), 1'b1, 1'b0, 1'b0, b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        sym_valid = 1'b1;
        sym_in    = 10'b0010101011;
        @(negedge clk);
        check("R7 in reset", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        rst = 1'b0;
        sym_valid = 1'b0;
        @(negedge clk);
        check("R7 after reset", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

        // R2 each control code
        for (int k = 0; k < 4; k++)
            step("R2 control code", 1'b1, code_of(k), 1'b0, k[0], k[1], 8'h00);

        // Exhaustive symbol sweep: R3 R4 R5 R6, with back-to-back strobes (R1)
        for (int v = 0; v < 1024; v++) begin
            logic [9:0] s;
            logic [7:0] e;
            int         hit;
            s = 10'(v);
            hit = -1;
            for (int k = 0; k < 4; k++) if (s == code_of(k)) hit = k;
            e[0] = s[0] ^ s[9];
            for (int i = 1; i < 8; i++) e[i] = s[i] ^ s[i-1] ^ ~s[8];
            if (hit >= 0) step("R2 R6 sweep", 1'b1, s, 1'b0, hit[0], hit[1], 8'h00);
            else          step("R3 R4 R5 sweep", 1'b1, s, 1'b1, 1'b0, 1'b0, e);
        end

        // R8 idle cycles hold the previous result
        step("R8 idle after data", 1'b0, 10'b1101010100, 1'b0, 1'b0, 1'b0, 8'h00);
        step("R2 code 2", 1'b1, code_of(2), 1'b0, 1'b0, 1'b1, 8'h00);
        step("R8 idle after control", 1'b0, 10'h1FF, 1'b0, 1'b0, 1'b0, 8'h00);

        // R5 round trip of every byte, then 500 pseudo-random bytes
        disp = 0;
        for (int b = 0; b < 256; b++) send_byte("R5 round trip all bytes", 8'(b));
        for (int n = 0; n < 500; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_byte("R5 round trip random", lfsr[7:0]);
        end

        // R1 a single strobe yields a single valid pulse
        step("R1 single pulse", 1'b1, encode(8'h5A), 1'b1, 1'b0, 1'b0, 8'h5A);
        step("R1 pulse ends", 1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 8'h00);

        // R7 reset in mid-stream
        @(negedge clk);
        sym_valid = 1'b1;
        sym_in = encode(8'hC3);
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid-stream reset", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        rst = 1'b0;
        sym_valid = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule